// File: doc/BRIEF.md
# Packed integer/float conversion unit

This unit converts a 64-bit packed operand that holds two 32-bit lanes between signed integers and IEEE-754 single-precision values. An 8-bit operation code selects one of three conversions:

- signed 16-bit words to float;
- signed 32-bit doublewords to float;
- float to signed 32-bit doubleword.

Every conversion rounds toward zero. Each lane is handled by its own copy of the same converter.

Operands are presented with a valid strobe and captured on the rising clock edge. The result, a valid strobe and an illegal-operation flag appear from the output registers one cycle later. Between strobes the outputs hold their last value. For the word variant, only the even words are used: word 0 feeds lane 0 and word 2 feeds lane 1. Each of these words is the low half of its lane's doubleword.

Float-to-integer conversion gives a fixed pattern, 0x80000000, when the input cannot be represented. Values below 1.0 in magnitude, zeros and denormals convert to zero. An unknown operation code gives a zero result and raises the illegal flag.

Top module: `pkcvt_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld`, `out_bad_op` and `out_res` are all 0 until the first accepted operand.
- R2: An operand accepted with `in_vld`=1 appears on `out_res`/`out_bad_op` after the next rising edge, with `out_vld`=1 for exactly that cycle. With `in_vld`=0, `out_vld` is 0 and `out_res`/`out_bad_op` keep their value.
- R3: With op 0x0C, source bits [15:0] and [47:32] are each taken as signed 16-bit values and converted to float32. The results go to result bits [31:0] and [63:32]. Source bits [31:16] and [63:48] have no effect.
- R4: With op 0x0D, source bits [31:0] and [63:32] are each taken as signed 32-bit integers and converted to float32 in the same bit positions of the result.
- R5: Integer-to-float conversion keeps the 24 most significant bits of the magnitude and drops the rest, which rounds toward zero. For example, 0x7FFFFFFF gives 0x4EFFFFFF.
- R6: An integer 0 converts to 0x00000000. A negative integer gives bit 31 set and the converted magnitude. For example, -1 gives 0xBF800000 and 0x80000000 gives 0xCF000000.
- R7: With op 0x1D, each float32 lane is converted to a signed 32-bit integer with the fraction truncated toward zero. For example, 1.5 gives 1 and -2.5 gives -2.
- R8: Float-to-integer conversion of a NaN, either infinity, or any value with magnitude 2^31 or more gives 0x80000000.
- R9: Float-to-integer conversion of a zero, a denormal, or any value with magnitude below 1.0 gives 0.
- R10: An op other than 0x0C, 0x0D or 0x1D sets `out_bad_op`=1 with `out_res`=0. A legal op gives `out_bad_op`=0.
- R11: The two lanes are converted independently. The value in one lane does not change the result of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand valid strobe |
| in_op | input | 8 | Operation code (0x0C, 0x0D, 0x1D) |
| in_src | input | 64 | Packed source operand, two 32-bit lanes |
| out_vld | output | 1 | Result valid strobe, one cycle after `in_vld` |
| out_res | output | 64 | Packed conversion result |
| out_bad_op | output | 1 | Illegal operation code seen |

## Verification
The hardest cases to reach are the edges of the float-to-integer range. These are 2^31, which must saturate, and the largest float just below it, which must not. They also include the exact value -2^31, which happens to give the same pattern as saturation. The stimulus sets these exponent and mantissa patterns directly, and places an edge value in one lane next to an ordinary value in the other.

Truncation is reached in the same way. The stimulus uses integers with 25 or more significant bits whose low bits would round up under round-to-nearest. For the word variant, the odd words are loaded with values that would change the result if they were wrongly selected.

// File: rtl/pkcvt_pkg.sv
package pkcvt_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 2;
  localparam int OP_W   = 8;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int HALF_W = 16;

  localparam logic [OP_W-1:0] OP_W2F = 8'h0C;
  localparam logic [OP_W-1:0] OP_D2F = 8'h0D;
  localparam logic [OP_W-1:0] OP_F2D = 8'h1D;

  function automatic logic op_legal(input logic [OP_W-1:0] op);
    return (op == OP_W2F) || (op == OP_D2F) || (op == OP_F2D);
  endfunction
endpackage

// File: rtl/pkcvt_i2f.sv
module pkcvt_i2f #(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [INT_W-1:0]         a,
  output logic [EXP_W+MAN_W:0]     y
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] shifted;
  int               lead;

  always_comb begin
    neg  = a[INT_W-1];
    mag  = neg ? (~a + 1'b1) : a;
    lead = 0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lead = i;
    end
    if (lead >= MAN_W) shifted = mag >> (lead - MAN_W);
    else               shifted = mag << (MAN_W - lead);
    if (mag == '0) y = '0;
    else           y = {neg, EXP_W'(BIAS + lead), shifted[MAN_W-1:0]};
  end
endmodule

// File: rtl/pkcvt_f2i.sv
module pkcvt_f2i #(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  output logic [INT_W-1:0]     y
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [INT_W-1:0] SAT = {1'b1, {(INT_W-1){1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [INT_W-1:0] sigx;
  logic [INT_W-1:0] mag;
  int               unb;

  always_comb begin
    sgn  = a[EXP_W+MAN_W];
    ex   = a[EXP_W+MAN_W-1:MAN_W];
    sigx = INT_W'({1'b1, a[MAN_W-1:0]});
    unb  = int'(ex) - BIAS;
    mag  = '0;
    if (ex == '1) begin
      y = SAT;
    end else if (unb < 0) begin
      y = '0;
    end else if (unb >= INT_W - 1) begin
      y = SAT;
    end else begin
      if (unb >= MAN_W) mag = sigx << (unb - MAN_W);
      else              mag = sigx >> (MAN_W - unb);
      y = sgn ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/pkcvt_lane.sv
module pkcvt_lane
  import pkcvt_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [LANE_W-1:0] src,
  output logic [LANE_W-1:0] res
);
  logic [LANE_W-1:0] int_in;
  logic [LANE_W-1:0] flt_out;
  logic [LANE_W-1:0] int_out;

  // the even word of the packed operand is the low half of this lane
  assign int_in = (op == OP_W2F) ? {{(LANE_W-HALF_W){src[HALF_W-1]}}, src[HALF_W-1:0]} : src;

  pkcvt_i2f #(.INT_W(LANE_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) i_i2f (
    .a(int_in), .y(flt_out)
  );

  pkcvt_f2i #(.INT_W(LANE_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) i_f2i (
    .a(src), .y(int_out)
  );

  always_comb begin
    if (op == OP_F2D)                        res = int_out;
    else if (op == OP_W2F || op == OP_D2F)   res = flt_out;
    else                                     res = '0;
  end
endmodule

// File: rtl/pkcvt_unit.sv
module pkcvt_unit
  import pkcvt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [OP_W-1:0]         in_op,
  input  logic [LANES*LANE_W-1:0] in_src,
  output logic                    out_vld,
  output logic [LANES*LANE_W-1:0] out_res,
  output logic                    out_bad_op
);
  localparam int TOT_W = LANES * LANE_W;
  localparam logic [LANE_W-1:0] SAT = {1'b1, {(LANE_W-1){1'b0}}};

  logic [TOT_W-1:0] lane_res;
  logic             legal;
  logic             vld_q,  vld_d;
  logic [TOT_W-1:0] res_q,  res_d;
  logic             bad_q,  bad_d;

  assign legal = op_legal(in_op);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pkcvt_lane i_lane (
      .op (in_op),
      .src(in_src[g*LANE_W +: LANE_W]),
      .res(lane_res[g*LANE_W +: LANE_W])
    );

    assert_f2i_small_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == OP_F2D && in_src[g*LANE_W+MAN_W +: EXP_W] < EXP_W'(127))
      |=> (out_res[g*LANE_W +: LANE_W] == '0));

    assert_f2i_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == OP_F2D && in_src[g*LANE_W+MAN_W +: EXP_W] == '1)
      |=> (out_res[g*LANE_W +: LANE_W] == SAT));

    assert_d2f_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == OP_D2F && in_src[g*LANE_W+LANE_W-1])
      |=> out_res[g*LANE_W+LANE_W-1]);
  end

  always_comb begin
    vld_d = in_vld;
    res_d = res_q;
    bad_d = bad_q;
    if (in_vld) begin
      res_d = legal ? lane_res : '0;
      bad_d = !legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      bad_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      bad_q <= bad_d;
    end
  end

  assign out_vld    = vld_q;
  assign out_res    = res_q;
  assign out_bad_op = bad_q;

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  assert_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_res) && $stable(out_bad_op)));

  assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op != OP_W2F && in_op != OP_D2F && in_op != OP_F2D)
    |=> (out_bad_op && out_res == '0));
endmodule

// File: tb/test_pkcvt_unit.sv
module test_pkcvt_unit;
  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [7:0]  in_op;
  logic [63:0] in_src;
  logic        out_vld;
  logic [63:0] out_res;
  logic        out_bad_op;

  int n_chk;
  int n_fail;
  bit done;

  pkcvt_unit i_pkcvt_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_src(in_src), .out_vld(out_vld), .out_res(out_res), .out_bad_op(out_bad_op)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NV = 12;
  // {op[7:0], src[63:0], expected[63:0]}
  localparam logic [135:0] VEC [NV] = '{
    {8'h0D, 64'h00000001_00000000, 64'h3F800000_00000000},  // R4 R6
    {8'h0D, 64'hFFFFFFFF_80000000, 64'hBF800000_CF000000},  // R6 R11
    {8'h0D, 64'h01FFFFFF_7FFFFFFF, 64'h4BFFFFFF_4EFFFFFF},  // R5
    {8'h0D, 64'h00000003_FFFFFFFD, 64'h40400000_C0400000},  // R4
    {8'h0C, 64'h1234FFFF_56780064, 64'hBF800000_42C80000},  // R3
    {8'h0C, 64'hAAAA8000_BBBB7FFF, 64'hC7000000_46FFFE00},  // R3
    {8'h1D, 64'h3FC00000_C0200000, 64'h00000001_FFFFFFFE},  // R7
    {8'h1D, 64'h7F800000_7FC00000, 64'h80000000_80000000},  // R8
    {8'h1D, 64'h4F000000_CF000000, 64'h80000000_80000000},  // R8
    {8'h1D, 64'h4EFFFFFF_3F7FFFFF, 64'h7FFFFF80_00000000},  // R7 R9
    {8'h1D, 64'h00000001_80000000, 64'h00000000_00000000},  // R9
    {8'h1D, 64'hBF000000_4B000001, 64'h00000000_00800001}   // R9 R11
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R4";
      1: return "R6";
      2: return "R5";
      3: return "R4";
      4: return "R3";
      5: return "R3";
      6: return "R7";
      7: return "R8";
      8: return "R8";
      9: return "R7";
      10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [63:0] src);
    @(negedge clk);
    in_vld = 1'b1;
    in_op  = op;
    in_src = src;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_vld = 1'b0; in_op = 8'h00; in_src = '0;
    repeat (3) @(negedge clk);
    check("R1", {62'd0, out_vld, out_bad_op}, 64'd0);
    check("R1", out_res, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, out_vld, out_bad_op}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][135:128], VEC[i][127:64]);
      check(tag_of(i), out_res, VEC[i][63:0]);
      check("R10", {63'd0, out_bad_op}, 64'd0);
      check("R2", {63'd0, out_vld}, 64'd1);
    end

    // R2: idle cycles hold the result and drop the strobe
    @(negedge clk);
    in_src = 64'hDEADBEEF_DEADBEEF; in_op = 8'h0D;
    @(negedge clk);
    @(negedge clk);
    check("R2", {63'd0, out_vld}, 64'd0);
    check("R2", out_res, 64'h00000000_00800001);

    // R3: odd words differ, result unchanged
    apply(8'h0C, 64'h0000FFFF_00000064);
    check("R3", out_res, 64'hBF800000_42C80000);

    // R10: illegal operation codes
    apply(8'h0E, 64'hFFFFFFFF_FFFFFFFF);
    check("R10", {63'd0, out_bad_op}, 64'd1);
    check("R10", out_res, 64'd0);
    apply(8'h1C, 64'h3F800000_3F800000);
    check("R10", {63'd0, out_bad_op}, 64'd1);
    check("R10", out_res, 64'd0);

    // back-to-back operands
    @(negedge clk);
    in_vld = 1'b1; in_op = 8'h0D; in_src = 64'h00000000_00000002;
    @(negedge clk);
    check("R6", out_res, 64'h00000000_40000000);
    check("R10", {63'd0, out_bad_op}, 64'd0);
    in_op = 8'h1D; in_src = 64'h42C80000_C2C80000;
    @(negedge clk);
    in_vld = 1'b0;
    check("R7", out_res, 64'h00000064_FFFFFF9C);
    check("R2", {63'd0, out_vld}, 64'd1);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    #1;
    check("R1", out_res, 64'd0);
    check("R1", {62'd0, out_vld, out_bad_op}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule